// File: doc/BRIEF.md
# Vector Instruction Decoder and Branch Unit

This block takes one 64-bit instruction word of a small vector core, together with the current program counter and the two 96-bit vector operands that the register file has already fetched for the instruction's source fields. It splits the word into its fields and flags whether the trailing 32 bits carry an immediate or two register addresses. It then works out where the program goes next.

A conditional jump compares one signed 32-bit component of the two operands. The opcode itself chooses which component and which relation to test, so the core keeps no condition-code flags. An unconditional jump and a call redirect to a target held in the immediate. A call also saves the return address on a small internal stack, and a return pops that address. Every other instruction advances the counter by one. Results are registered and appear one cycle after the input strobe.

Top module: `vec_branch_unit`

## Requirements
- R1: The word splits as opcode = bits 63:48, destination = bits 47:32, first source = bits 31:16 and second source = bits 15:0. The destination appears on `dst_addr`.
- R2: `imm_fmt` equals opcode bit 6 (word bit 54). `imm_val` equals word bits 31:0.
- R3: `out_valid` rises exactly one cycle after `in_valid`. While `in_valid` is low, `next_pc` and `branch_taken` hold their values.
- R4: A conditional jump tests a vector component chosen by opcode bits 4:3: 01 selects x (bits 95:64), 10 selects y (bits 63:32) and 11 selects z (bits 31:0). Each component is compared as a signed 32-bit value.
- R5: Opcode bits 2:0 of a conditional jump choose the relation a ? b: 000 greater, 001 less, 010 equal, 011 not equal, 100 greater-or-equal, 101 less-or-equal.
- R6: Any opcode that is not a jump, call or return gives `branch_taken` = 0 and `next_pc` = pc+1, modulo 2^16. This includes 0x000E, 0x000F, 0x0016 and 0x0017, which sit inside the jump range.
- R7: When a conditional jump is taken, `next_pc` is the destination field. When it is not taken, `next_pc` is pc+1.
- R8: Opcode 0x0058 always jumps to immediate bits 15:0.
- R9: Opcode 0x0059 pushes pc+1 onto the return stack and jumps to immediate bits 15:0.
- R10: Opcode 0x005A pops the most recent saved address into `next_pc` with `branch_taken` = 1, so the stack returns addresses in last-in, first-out order.
- R11: A call when 4 addresses are already saved sets `stack_err`. The push is dropped, but the call still jumps.
- R12: A return with an empty stack sets `stack_err` and gives `branch_taken` = 0 and `next_pc` = pc+1.
- R13: `stack_err` stays set until reset. Reset clears all outputs and empties the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 64 | Instruction word |
| pc | input | 16 | Address of the instruction |
| vec_a | input | 96 | Vector read through the first source field |
| vec_b | input | 96 | Vector read through the second source field |
| out_valid | output | 1 | Registered result valid |
| next_pc | output | 16 | Next program counter |
| branch_taken | output | 1 | Flow redirected away from pc+1 |
| imm_fmt | output | 1 | Trailing 32 bits are an immediate |
| dst_addr | output | 16 | Destination field |
| src1_addr | output | 16 | First source field |
| src2_addr | output | 16 | Second source field |
| imm_val | output | 32 | Immediate field |
| stack_err | output | 1 | Sticky return-stack overflow/underflow |

## Verification
The following properties are checked on every cycle:
- the one-cycle latency and the holding of the outputs between strobes;
- the immediate flag;
- the pc+1 path for the non-jump opcodes inside the jump range;
- the target of a taken conditional jump and of an unconditional jump;
- the stickiness of the error flag.

Some behaviours need state or data that only directed scenarios supply, so the bench covers them:
- the signed compare on every axis and relation;
- the last-in, first-out order of nested calls;
- the dropped push on overflow;
- the fall-through on underflow;
- the counter wrapping at 0xFFFF.

// File: rtl/vbu_pkg.sv
package vbu_pkg;

    localparam logic [15:0] OP_JUMP   = 16'h0058;
    localparam logic [15:0] OP_CALL   = 16'h0059;
    localparam logic [15:0] OP_RETURN = 16'h005A;

    typedef enum logic [2:0] {
        K_SEQ,
        K_COND,
        K_JUMP,
        K_CALL,
        K_RET
    } flow_kind_e;

    typedef enum logic [2:0] {
        REL_GT = 3'b000,
        REL_LT = 3'b001,
        REL_EQ = 3'b010,
        REL_NE = 3'b011,
        REL_GE = 3'b100,
        REL_LE = 3'b101
    } rel_e;

endpackage

// File: rtl/vbu_decode.sv
module vbu_decode
    import vbu_pkg::*;
#(
    parameter int FW = 16
) (
    input  logic [4*FW-1:0] word,
    output logic [FW-1:0]   opcode,
    output logic [FW-1:0]   dst,
    output logic [FW-1:0]   src1,
    output logic [FW-1:0]   src2,
    output logic [2*FW-1:0] imm,
    output logic            is_imm,
    output flow_kind_e      kind,
    output logic [1:0]      axis,
    output logic [2:0]      rel
);
    logic cond_hit;

    always_comb begin
        opcode = word[4*FW-1:3*FW];
        dst    = word[3*FW-1:2*FW];
        src1   = word[2*FW-1:FW];
        src2   = word[FW-1:0];
        imm    = word[2*FW-1:0];
        is_imm = opcode[6];
        axis   = opcode[4:3];
        rel    = opcode[2:0];
        // conditional jumps: 0_0aa_rrr with aa != 00 and rrr <= 101
        cond_hit = (opcode[FW-1:5] == '0) && (opcode[4:3] != 2'b00)
                && (opcode[2:1] != 2'b11);
        if (cond_hit)                         kind = K_COND;
        else if (opcode == FW'(OP_JUMP))      kind = K_JUMP;
        else if (opcode == FW'(OP_CALL))      kind = K_CALL;
        else if (opcode == FW'(OP_RETURN))    kind = K_RET;
        else                                  kind = K_SEQ;
    end
endmodule

// File: rtl/vbu_compare.sv
module vbu_compare
    import vbu_pkg::*;
#(
    parameter int CW    = 32,
    parameter int NCOMP = 3
) (
    input  logic [NCOMP*CW-1:0] a,
    input  logic [NCOMP*CW-1:0] b,
    input  logic [1:0]          axis,
    input  logic [2:0]          rel,
    output logic                hit
);
    logic signed [CW-1:0] ca [NCOMP];
    logic signed [CW-1:0] cb [NCOMP];

    // component 0 (x) sits in the top slice
    for (genvar g = 0; g < NCOMP; g++) begin : g_split
        assign ca[g] = a[(NCOMP-g)*CW-1 -: CW];
        assign cb[g] = b[(NCOMP-g)*CW-1 -: CW];
    end

    logic signed [CW-1:0] sa, sb;

    always_comb begin
        sa = ca[0];
        sb = cb[0];
        for (int i = 0; i < NCOMP; i++) begin
            if (32'(axis) == i + 1) begin
                sa = ca[i];
                sb = cb[i];
            end
        end
        case (rel)
            REL_GT:  hit = sa >  sb;
            REL_LT:  hit = sa <  sb;
            REL_EQ:  hit = sa == sb;
            REL_NE:  hit = sa != sb;
            REL_GE:  hit = sa >= sb;
            REL_LE:  hit = sa <= sb;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/vec_branch_unit.sv
module vec_branch_unit
    import vbu_pkg::*;
#(
    parameter int FW    = 16,
    parameter int CW    = 32,
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [63:0]     instr,
    input  logic [15:0]     pc,
    input  logic [95:0]     vec_a,
    input  logic [95:0]     vec_b,
    output logic            out_valid,
    output logic [15:0]     next_pc,
    output logic            branch_taken,
    output logic            imm_fmt,
    output logic [15:0]     dst_addr,
    output logic [15:0]     src1_addr,
    output logic [15:0]     src2_addr,
    output logic [31:0]     imm_val,
    output logic            stack_err
);
    localparam int NCOMP = 3;
    localparam int SPW   = $clog2(DEPTH + 1);
    localparam int IDXW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic                       valid;
        logic [FW-1:0]              npc;
        logic                       taken;
        logic                       fmt;
        logic [FW-1:0]              dst;
        logic [FW-1:0]              s1;
        logic [FW-1:0]              s2;
        logic [2*FW-1:0]            imm;
        logic                       err;
        logic [SPW-1:0]             sp;
        logic [DEPTH-1:0][FW-1:0]   stk;
    } state_t;

    state_t q, d;

    logic [FW-1:0]   f_op, f_dst, f_s1, f_s2;
    logic [2*FW-1:0] f_imm;
    logic            f_is_imm;
    flow_kind_e      f_kind;
    logic [1:0]      f_axis;
    logic [2:0]      f_rel;
    logic            cmp_hit;

    vbu_decode #(.FW(FW)) u_dec (
        .word(instr), .opcode(f_op), .dst(f_dst), .src1(f_s1), .src2(f_s2),
        .imm(f_imm), .is_imm(f_is_imm), .kind(f_kind), .axis(f_axis), .rel(f_rel)
    );

    vbu_compare #(.CW(CW), .NCOMP(NCOMP)) u_cmp (
        .a(vec_a), .b(vec_b), .axis(f_axis), .rel(f_rel), .hit(cmp_hit)
    );

    logic [FW-1:0]  seq_pc;
    logic [SPW-1:0] sp_dec;

    always_comb begin
        seq_pc  = pc + 1'b1;
        sp_dec  = q.sp - 1'b1;
        d       = q;
        d.valid = in_valid;
        if (in_valid) begin
            d.fmt   = f_is_imm;
            d.dst   = f_dst;
            d.s1    = f_s1;
            d.s2    = f_s2;
            d.imm   = f_imm;
            d.taken = 1'b0;
            d.npc   = seq_pc;
            case (f_kind)
                K_COND: begin
                    d.taken = cmp_hit;
                    if (cmp_hit) d.npc = f_dst;
                end
                K_JUMP: begin
                    d.taken = 1'b1;
                    d.npc   = f_imm[FW-1:0];
                end
                K_CALL: begin
                    d.taken = 1'b1;
                    d.npc   = f_imm[FW-1:0];
                    if (q.sp == SPW'(DEPTH)) begin
                        d.err = 1'b1;
                    end else begin
                        d.stk[q.sp[IDXW-1:0]] = seq_pc;
                        d.sp = q.sp + 1'b1;
                    end
                end
                K_RET: begin
                    if (q.sp == '0) begin
                        d.err = 1'b1;
                    end else begin
                        d.taken = 1'b1;
                        d.npc   = q.stk[sp_dec[IDXW-1:0]];
                        d.sp    = sp_dec;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid    = q.valid;
    assign next_pc      = q.npc;
    assign branch_taken = q.taken;
    assign imm_fmt      = q.fmt;
    assign dst_addr     = q.dst;
    assign src1_addr    = q.s1;
    assign src2_addr    = q.s2;
    assign imm_val      = q.imm;
    assign stack_err    = q.err;
endmodule

// File: rtl/vbu_checker.sv
module vbu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] instr,
    input logic [15:0] pc,
    input logic        out_valid,
    input logic [15:0] next_pc,
    input logic        branch_taken,
    input logic        imm_fmt,
    input logic        stack_err
);
    logic [15:0] op;
    logic        plain_in_range, cond_op;
    assign op = instr[63:48];
    assign plain_in_range = (op == 16'h000E) || (op == 16'h000F)
                         || (op == 16'h0016) || (op == 16'h0017);
    assign cond_op = (op[15:5] == 11'd0) && (op[4:3] != 2'b00) && (op[2:1] != 2'b11);

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(next_pc) && $stable(branch_taken));
    p_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> imm_fmt == $past(instr[54]));
    p_no_branch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && plain_in_range |=> !branch_taken && next_pc == 16'($past(pc) + 16'd1));
    p_cond_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && cond_op |=> (branch_taken ? next_pc == $past(instr[47:32])
                                              : next_pc == 16'($past(pc) + 16'd1)));
    p_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && op == 16'h0058 |=> branch_taken && next_pc == $past(instr[15:0]));
    p_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        stack_err |=> stack_err);
endmodule

bind vec_branch_unit vbu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
    .out_valid(out_valid), .next_pc(next_pc), .branch_taken(branch_taken),
    .imm_fmt(imm_fmt), .stack_err(stack_err)
);

// File: tb/sim_vec_branch_unit.sv
module sim_vec_branch_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [15:0] pc = '0;
    logic [95:0] vec_a = '0, vec_b = '0;
    logic        out_valid, branch_taken, imm_fmt, stack_err;
    logic [15:0] next_pc, dst_addr, src1_addr, src2_addr;
    logic [31:0] imm_val;

    always #5 clk = ~clk;

    vec_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .pc(pc),
        .vec_a(vec_a), .vec_b(vec_b), .out_valid(out_valid), .next_pc(next_pc),
        .branch_taken(branch_taken), .imm_fmt(imm_fmt), .dst_addr(dst_addr),
        .src1_addr(src1_addr), .src2_addr(src2_addr), .imm_val(imm_val),
        .stack_err(stack_err)
    );

    typedef struct {
        logic [15:0] npc;
        bit          tk;
        bit          fmt;
        logic [15:0] dst;
        logic [31:0] imm;
        bit          err;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] op, input logic [15:0] dst,
                                       input logic [15:0] s1, input logic [15:0] s2);
        return {op, dst, s1, s2};
    endfunction

    function automatic logic [95:0] vec(input int x, input int y, input int z);
        return {x[31:0], y[31:0], z[31:0]};
    endfunction

    task automatic drive(input logic [63:0] ins, input logic [15:0] p,
                         input logic [95:0] a, input logic [95:0] b,
                         input logic [15:0] epc, input bit etk, input bit eerr, input string tag);
        exp_t e;
        @(negedge clk);
        instr = ins; pc = p; vec_a = a; vec_b = b; in_valid = 1'b1;
        e.npc = epc; e.tk = etk; e.fmt = ins[54]; e.dst = ins[47:32];
        e.imm = ins[31:0]; e.err = eerr; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor
    always begin
        @(posedge clk);
        #2;
        if (out_valid && rst_n) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected out_valid", 32'(out_valid), 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(next_pc == e.npc, {e.tag, " next_pc"}, 32'(next_pc), 32'(e.npc));
                check(branch_taken == e.tk, {e.tag, " taken"}, 32'(branch_taken), 32'(e.tk));
                check(stack_err == e.err, {e.tag, " R11 R12 stack_err"}, 32'(stack_err), 32'(e.err));
                check(dst_addr == e.dst, {e.tag, " R1 dst"}, 32'(dst_addr), 32'(e.dst));
                check(imm_fmt == e.fmt && imm_val == e.imm, {e.tag, " R2 imm"}, imm_val, e.imm);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 0 && next_pc == 0 && stack_err == 0 && branch_taken == 0,
              "R13 reset state", {15'd0, out_valid, next_pc}, 32'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R6 plain op, R1 fields
        drive(mk(16'h0000, 16'h0042, 16'h0007, 16'h0009), 16'd10, '0, '0, 16'd11, 0, 0, "R6 nop");
        // R4 R5 R7 conditional jumps
        drive(mk(16'h0008, 16'd100, 1, 2), 16'd20, vec(5, 0, 0), vec(-3, 0, 0), 16'd100, 1, 0, "R5 gt x taken");
        drive(mk(16'h0009, 16'd100, 1, 2), 16'd21, vec(5, 0, 0), vec(-3, 0, 0), 16'd22, 0, 0, "R7 lt x not taken");
        drive(mk(16'h0012, 16'd200, 1, 2), 16'd30, vec(1, 7, 0), vec(2, 7, 0), 16'd200, 1, 0, "R4 eq y");
        drive(mk(16'h001B, 16'd300, 1, 2), 16'd31, vec(1, 2, 9), vec(3, 4, 9), 16'd32, 0, 0, "R4 ne z equal");
        drive(mk(16'h001C, 16'd301, 1, 2), 16'd33, vec(1, 2, 9), vec(3, 4, 9), 16'd301, 1, 0, "R5 ge z");
        drive(mk(16'h000D, 16'd400, 1, 2), 16'd40, vec(-1, 0, 0), vec(1, 0, 0), 16'd400, 1, 0, "R4 signed le x");
        drive(mk(16'h0018, 16'd401, 1, 2), 16'd41, vec(0, 0, -5), vec(0, 0, 4), 16'd42, 0, 0, "R4 signed gt z");
        // R6 non-jump in range
        drive(mk(16'h000E, 16'd500, 1, 2), 16'd50, vec(1, 1, 1), vec(1, 1, 1), 16'd51, 0, 0, "R6 0x0E");
        drive(mk(16'h000F, 16'd500, 1, 2), 16'd51, vec(1, 1, 1), vec(1, 1, 1), 16'd52, 0, 0, "R6 0x0F");
        drive(mk(16'h0016, 16'd500, 1, 2), 16'd52, vec(1, 1, 1), vec(1, 1, 1), 16'd53, 0, 0, "R6 0x16");
        drive(mk(16'h0017, 16'd500, 1, 2), 16'd53, vec(1, 1, 1), vec(1, 1, 1), 16'd54, 0, 0, "R6 0x17");
        drive(mk(16'h0041, 16'd3, 16'hDEAD, 16'hBEEF), 16'd60, '0, '0, 16'd61, 0, 0, "R2 type II");
        drive(mk(16'hFFFF, 16'd3, 0, 0), 16'hFFFF, '0, '0, 16'h0000, 0, 0, "R6 wrap");
        // R8 jump
        drive(mk(16'h0058, 16'd0, 16'h0000, 16'h0123), 16'd70, '0, '0, 16'h0123, 1, 0, "R8 jump");
        // R3 hold while idle
        repeat (4) @(negedge clk);
        check(next_pc == 16'h0123 && branch_taken && !out_valid, "R3 hold", 32'(next_pc), 32'h0123);
        // R9 R10 nested call/return
        drive(mk(16'h0059, 0, 0, 16'h0300), 16'h0020, '0, '0, 16'h0300, 1, 0, "R9 call1");
        drive(mk(16'h0059, 0, 0, 16'h0400), 16'h0300, '0, '0, 16'h0400, 1, 0, "R9 call2");
        drive(mk(16'h005A, 0, 0, 0), 16'h0400, '0, '0, 16'h0301, 1, 0, "R10 ret inner");
        drive(mk(16'h005A, 0, 0, 0), 16'h0302, '0, '0, 16'h0021, 1, 0, "R10 ret outer");
        // R12 underflow, R13 sticky
        drive(mk(16'h005A, 0, 0, 0), 16'h0050, '0, '0, 16'h0051, 0, 1, "R12 underflow");
        drive(mk(16'h0000, 0, 0, 0), 16'h0060, '0, '0, 16'h0061, 0, 1, "R13 sticky");
        repeat (3) @(negedge clk);
        do_reset();
        // R11 overflow
        for (int i = 0; i < 4; i++)
            drive(mk(16'h0059, 0, 0, 16'(16'h1000 + i * 16)), 16'(16'h0100 + i * 16), '0, '0,
                  16'(16'h1000 + i * 16), 1, 0, "R9 fill");
        drive(mk(16'h0059, 0, 0, 16'h2000), 16'h0800, '0, '0, 16'h2000, 1, 1, "R11 overflow");
        for (int i = 3; i >= 0; i--)
            drive(mk(16'h005A, 0, 0, 0), 16'h0900, '0, '0, 16'(16'h0101 + i * 16), 1, 1, "R11 push dropped");
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all results seen", 32'(exp_q.size()), 32'd0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule